// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit sits in the execute stage of an integer pipeline and prepares the addressing side of word, byte and halfword memory accesses. It takes a base register value and one of three offset forms. The forms are a 12-bit immediate, a full register value, or an 8-bit immediate assembled from two 4-bit fields. From these it produces the memory address, the access size and the sign-extension control for loads. It also produces the value to write back into the base register and a flag that enables that writeback.

A request is presented with `in_valid` high and its results appear on the outputs one clock later, qualified by `out_valid`. The offset is always added: when the direction bit is clear, the offset is negated first. The indexing bit chooses between two modes. In pre-indexed mode the sum is used as the address. In post-indexed mode the unmodified base is used as the address and the sum is returned as the new base.

A small extender also uses the size and sign controls held in the output register to widen raw load data to the full data width. The unit has no state machine: one register stage separates the request from its results.

Top module: `lsag_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `out_valid` and `wb_en` are 0.
- R2: With `pre_idx`=1, both `mem_addr` and `wb_val` equal `base_val` plus the signed displacement.
- R3: With `pre_idx`=0, `mem_addr` equals `base_val` unchanged and `wb_val` equals `base_val` plus the signed displacement.
- R4: `wb_en` is 1 for a post-indexed request regardless of `wback`, and for a pre-indexed request only when `wback`=1.
- R5: With `up`=1 the displacement is the offset magnitude; with `up`=0 it is its two's complement (the magnitude is subtracted modulo 2^32).
- R6: `ofs_form` selects the magnitude: 0 is `imm12` zero-extended, 1 is `reg_off`, 2 is {`nib_hi`,`nib_lo`} zero-extended, and 3 behaves as 0.
- R7: `kind` encodes 0 word, 1 unsigned byte, 2 unsigned halfword, 3 signed byte, 4 signed halfword (5..7 behave as word). `acc_size` reports 0 for byte, 1 for halfword and 2 for word.
- R8: `sign_ext` is 1 only for a load (`is_load`=1) of kind 3 or 4; stores of those kinds report 0.
- R9: For a load whose `dest_idx` equals `base_idx`, `wb_en` is 0, so the loaded value owns the register.
- R10: `ld_ext` returns `ld_raw` widened per the registered size: byte and halfword are sign-extended when `sign_ext`=1 and zero-extended otherwise; word passes through.
- R11: Results of a request appear exactly one clock after it is accepted. A cycle with `in_valid`=0 yields `out_valid`=0 and `wb_en`=0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| base_val | input | 32 | Base register value |
| base_idx | input | 4 | Base register number |
| dest_idx | input | 4 | Data register number |
| ofs_form | input | 2 | Offset form select |
| imm12 | input | 12 | Plain immediate offset |
| reg_off | input | 32 | Register offset value |
| nib_hi | input | 4 | Upper half of split immediate |
| nib_lo | input | 4 | Lower half of split immediate |
| pre_idx | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| up | input | 1 | 1 = add offset, 0 = subtract |
| wback | input | 1 | Writeback request for pre-indexed mode |
| is_load | input | 1 | 1 = load, 0 = store |
| kind | input | 3 | Access kind code |
| ld_raw | input | 32 | Raw data returned by memory |
| out_valid | output | 1 | Results valid |
| mem_addr | output | 32 | Effective memory address |
| acc_size | output | 2 | Access size code |
| sign_ext | output | 1 | Sign-extend loaded data |
| wb_val | output | 32 | New base register value |
| wb_en | output | 1 | Base writeback enable |
| ld_ext | output | 32 | Widened load data |

## Verification
The assertions take `in_valid` to be low during and right after reset, since they compare outputs against the request seen one clock earlier. They also take the register numbers to be meaningful only while `in_valid` is high. The stimulus drives `in_valid` low throughout reset and changes inputs only at the falling edge. It then sweeps every combination of offset form, direction, indexing, writeback, load/store, kind and base/data register aliasing over three bases chosen to wrap at both ends of the address range.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
    typedef enum logic [2:0] {
        KIND_WORD  = 3'd0,
        KIND_UBYTE = 3'd1,
        KIND_UHALF = 3'd2,
        KIND_SBYTE = 3'd3,
        KIND_SHALF = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        OFS_IMM   = 2'd0,
        OFS_REG   = 2'd1,
        OFS_SPLIT = 2'd2,
        OFS_RSVD  = 2'd3
    } ofs_form_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;
endpackage

// File: rtl/lsag_offset_sel.sv
module lsag_offset_sel
    import lsag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12,
    parameter int NIB_W  = 4
) (
    input  logic [1:0]        form,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] reg_off,
    input  logic [NIB_W-1:0]  nib_hi,
    input  logic [NIB_W-1:0]  nib_lo,
    input  logic              up,
    output logic [DATA_W-1:0] disp
);
    localparam int IMM_PAD   = DATA_W - IMM_W;
    localparam int SPLIT_PAD = DATA_W - 2 * NIB_W;

    logic [DATA_W-1:0] mag;

    always_comb begin
        case (ofs_form_e'(form))
            OFS_REG:   mag = reg_off;
            OFS_SPLIT: mag = {{SPLIT_PAD{1'b0}}, nib_hi, nib_lo};
            default:   mag = {{IMM_PAD{1'b0}}, imm};
        endcase
    end

    // Direction bit folds subtraction into a single adder downstream.
    assign disp = up ? mag : (~mag + {{(DATA_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/lsag_addr_calc.sv
module lsag_addr_calc #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] disp,
    input  logic              pre_idx,
    input  logic              wback,
    input  logic              is_load,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [IDX_W-1:0]  dest_idx,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] new_base,
    output logic              wb_req
);
    logic [DATA_W-1:0] sum;
    logic              alias_load;

    assign sum        = base + disp;
    assign alias_load = is_load && (base_idx == dest_idx);
    assign addr       = pre_idx ? sum : base;
    assign new_base   = sum;
    assign wb_req     = (!pre_idx || wback) && !alias_load;
endmodule

// File: rtl/lsag_load_ext.sv
module lsag_load_ext
    import lsag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size,
    input  logic              sign_ext,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] ext
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: ext = {{(DATA_W-BYTE_W){sign_ext & raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
            SZ_HALF: ext = {{(DATA_W-HALF_W){sign_ext & raw[HALF_W-1]}}, raw[HALF_W-1:0]};
            default: ext = raw;
        endcase
    end
endmodule

// File: rtl/lsag_top.sv
module lsag_top
    import lsag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int IMM_W  = 12,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] base_val,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [IDX_W-1:0]  dest_idx,
    input  logic [1:0]        ofs_form,
    input  logic [IMM_W-1:0]  imm12,
    input  logic [DATA_W-1:0] reg_off,
    input  logic [NIB_W-1:0]  nib_hi,
    input  logic [NIB_W-1:0]  nib_lo,
    input  logic              pre_idx,
    input  logic              up,
    input  logic              wback,
    input  logic              is_load,
    input  logic [2:0]        kind,
    input  logic [DATA_W-1:0] ld_raw,
    output logic              out_valid,
    output logic [DATA_W-1:0] mem_addr,
    output logic [1:0]        acc_size,
    output logic              sign_ext,
    output logic [DATA_W-1:0] wb_val,
    output logic              wb_en,
    output logic [DATA_W-1:0] ld_ext
);
    logic [DATA_W-1:0] disp;
    logic [DATA_W-1:0] addr_c;
    logic [DATA_W-1:0] new_base_c;
    logic              wb_req_c;
    acc_size_e         size_c;
    logic              sext_c;

    lsag_offset_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .NIB_W(NIB_W)) u_ofs (
        .form(ofs_form), .imm(imm12), .reg_off(reg_off),
        .nib_hi(nib_hi), .nib_lo(nib_lo), .up(up), .disp(disp)
    );

    lsag_addr_calc #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_calc (
        .base(base_val), .disp(disp), .pre_idx(pre_idx), .wback(wback),
        .is_load(is_load), .base_idx(base_idx), .dest_idx(dest_idx),
        .addr(addr_c), .new_base(new_base_c), .wb_req(wb_req_c)
    );

    // Kind decode: signedness only matters for loads.
    always_comb begin
        size_c = SZ_WORD;
        sext_c = 1'b0;
        case (acc_kind_e'(kind))
            KIND_UBYTE: size_c = SZ_BYTE;
            KIND_UHALF: size_c = SZ_HALF;
            KIND_SBYTE: begin size_c = SZ_BYTE; sext_c = is_load; end
            KIND_SHALF: begin size_c = SZ_HALF; sext_c = is_load; end
            default:    size_c = SZ_WORD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
            mem_addr  <= '0;
            wb_val    <= '0;
            acc_size  <= SZ_WORD;
            sign_ext  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wb_en     <= in_valid && wb_req_c;
            if (in_valid) begin
                mem_addr <= addr_c;
                wb_val   <= new_base_c;
                acc_size <= size_c;
                sign_ext <= sext_c;
            end
        end
    end

    lsag_load_ext #(.DATA_W(DATA_W)) u_ext (
        .size(acc_size), .sign_ext(sign_ext), .raw(ld_raw), .ext(ld_ext)
    );

    p_wb_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> out_valid);
    p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));
    p_post_addr_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pre_idx) |=> (mem_addr == $past(base_val)));
    p_pre_addr_eq_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pre_idx) |=> (mem_addr == wb_val));
    p_pre_no_w_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pre_idx && !wback) |=> !wb_en);
    p_alias_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_load && (dest_idx == base_idx)) |=> !wb_en);
    p_store_no_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_load) |=> !sign_ext);
endmodule

// File: tb/lsag_top_tb.sv
`timescale 1ns/1ps
module lsag_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [3:0]  base_idx = '0;
    logic [3:0]  dest_idx = '0;
    logic [1:0]  ofs_form = '0;
    logic [11:0] imm12 = '0;
    logic [31:0] reg_off = '0;
    logic [3:0]  nib_hi = '0;
    logic [3:0]  nib_lo = '0;
    logic        pre_idx = 1'b0;
    logic        up = 1'b0;
    logic        wback = 1'b0;
    logic        is_load = 1'b0;
    logic [2:0]  kind = '0;
    logic [31:0] ld_raw = '0;
    logic        out_valid;
    logic [31:0] mem_addr;
    logic [1:0]  acc_size;
    logic        sign_ext;
    logic [31:0] wb_val;
    logic        wb_en;
    logic [31:0] ld_ext;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsag_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
        .base_idx(base_idx), .dest_idx(dest_idx), .ofs_form(ofs_form),
        .imm12(imm12), .reg_off(reg_off), .nib_hi(nib_hi), .nib_lo(nib_lo),
        .pre_idx(pre_idx), .up(up), .wback(wback), .is_load(is_load),
        .kind(kind), .ld_raw(ld_raw), .out_valid(out_valid),
        .mem_addr(mem_addr), .acc_size(acc_size), .sign_ext(sign_ext),
        .wb_val(wb_val), .wb_en(wb_en), .ld_ext(ld_ext)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ext_of(input logic [1:0] sz, input logic sx, input logic [31:0] r);
        if (sz == 2'd0) return sx ? {{24{r[7]}}, r[7:0]} : {24'd0, r[7:0]};
        if (sz == 2'd1) return sx ? {{16{r[15]}}, r[15:0]} : {16'd0, r[15:0]};
        return r;
    endfunction

    task automatic run_one(input logic [31:0] b, input int fm, input logic [11:0] im,
                           input logic [31:0] ro, input logic [7:0] nb,
                           input bit p, input bit u, input bit w, input bit ld,
                           input int k, input bit same);
        logic [31:0] mag, dsp, sum, eaddr;
        logic [1:0]  esz;
        logic        esx, ewb;
        // R6 magnitude selection
        if (fm == 1) mag = ro;
        else if (fm == 2) mag = {24'd0, nb};
        else mag = {20'd0, im};
        dsp = u ? mag : (32'd0 - mag);               // R5
        sum = b + dsp;
        eaddr = p ? sum : b;                          // R2 / R3
        ewb = (!p || w) && !(ld && same);             // R4 / R9
        esz = (k == 1 || k == 3) ? 2'd0 : (k == 2 || k == 4) ? 2'd1 : 2'd2; // R7
        esx = ld && (k == 3 || k == 4);               // R8
        @(negedge clk);
        in_valid = 1'b1; base_val = b; ofs_form = fm[1:0]; imm12 = im; reg_off = ro;
        nib_hi = nb[7:4]; nib_lo = nb[3:0]; pre_idx = p; up = u; wback = w;
        is_load = ld; kind = k[2:0]; base_idx = 4'd5; dest_idx = same ? 4'd5 : 4'd9;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 out_valid", {31'd0, out_valid}, 32'd1);
        chk(p ? "R2 mem_addr" : "R3 mem_addr", mem_addr, eaddr);
        chk("R5 wb_val", wb_val, sum);
        chk(same ? "R9 wb_en" : "R4 wb_en", {31'd0, wb_en}, {31'd0, ewb});
        chk("R7 acc_size", {30'd0, acc_size}, {30'd0, esz});
        chk("R8 sign_ext", {31'd0, sign_ext}, {31'd0, esx});
        ld_raw = 32'h1234_F38C; #1;
        chk("R10 ld_ext neg", ld_ext, ext_of(esz, esx, 32'h1234_F38C));
        ld_raw = 32'h89AB_7A5C; #1;
        chk("R10 ld_ext pos", ld_ext, ext_of(esz, esx, 32'h89AB_7A5C));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] bases [3];
        logic [11:0] imms  [3];
        logic [31:0] regs  [3];
        logic [7:0]  nibs  [3];
        bases = '{32'h0000_1000, 32'h0000_0000, 32'hFFFF_FFF0};
        imms  = '{12'h004, 12'hFFF, 12'h123};
        regs  = '{32'h0000_0010, 32'h8000_0000, 32'h0000_0007};
        nibs  = '{8'h12, 8'hFF, 8'h00};
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R1 wb_en in reset", {31'd0, wb_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R1 wb_en after reset", {31'd0, wb_en}, 32'd0);
        for (int bi = 0; bi < 3; bi++)
          for (int fm = 0; fm < 4; fm++)
            for (int p = 0; p < 2; p++)
              for (int u = 0; u < 2; u++)
                for (int w = 0; w < 2; w++)
                  for (int ld = 0; ld < 2; ld++)
                    for (int k = 0; k < 6; k++)
                      for (int s = 0; s < 2; s++)
                        run_one(bases[bi], fm, imms[bi], regs[bi], nibs[bi],
                                p[0], u[0], w[0], ld[0], k, s[0]);
        // R11: idle cycle after a request drops valid and writeback
        run_one(32'h40, 0, 12'h8, 32'h0, 8'h0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0);
        @(negedge clk);
        chk("R11 idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R11 idle wb_en", {31'd0, wb_en}, 32'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule